// File: doc/BRIEF.md
# Chip Reset Sequencer

This block turns two hardware reset requests, a power-on detect and an active-low board reset pin, into a single internal chip reset. It also runs the steps that follow each request. After power-on the reset is stretched by a timer derived from the clock frequency. The block then starts a configuration-memory load and holds the host-visible READY flag low until that load reports completion. A pin reset is accepted only after the synchronized pin has stayed low for a minimum number of cycles, and it lasts as long as the pin stays low. When either hardware reset ends, the block sends a one-cycle request that puts the PHY into general power-down.

A soft-reset request gives a short, fixed-length internal reset that clears READY and reloads nothing. While the chip is unpowered, everything is held in reset and the pin has no effect. When the unpowered indication drops, the block runs the full power-on sequence. Board-level pull-up of the pin is outside this block: an unconnected pin reads high and is therefore inactive.

Top module: `chip_reset_seq`

## Requirements
- R1: While porDetect or unpowered is 1, the next clock edge puts chipRst at 1 and ready, eeLoadStart and phyPowerDown at 0, and they stay so.
- R2: Once porDetect and unpowered are both sampled 0, chipRst falls at the POR_CYCLES-th such rising edge, where POR_CYCLES = CLK_KHZ*POR_STRETCH_US/1000.
- R3: At the edge where the power-on stretch ends, eeLoadStart and phyPowerDown each pulse to 1 for exactly one cycle.
- R4: After the power-on stretch, ready stays 0 and chipRst stays 0 until eeLoadDone is sampled 1; ready is 1 after that edge.
- R5: With ready at 1, extRstN held low for PIN_MIN_CYCLES sampled cycles drives chipRst to 1 and ready to 0 by the (PIN_MIN_CYCLES+3)-th rising edge, and chipRst stays 1 while the pin stays low.
- R6: An extRstN low pulse of fewer than PIN_MIN_CYCLES sampled cycles leaves chipRst at 0 and ready at 1.
- R7: After a pin reset, chipRst falls and ready rises at the third rising edge that samples extRstN high; phyPowerDown pulses for that one cycle and eeLoadStart stays 0.
- R8: While unpowered is 1, extRstN is ignored; when unpowered falls, the power-on sequence of R2 and R3 runs.
- R9: softRstReq sampled 1 while ready is 1 holds chipRst at 1 for exactly SOFT_CYCLES cycles, with no eeLoadStart or phyPowerDown pulse, and ready returns to 1 afterwards.
- R10: softRstReq is ignored while ready is 0, including during the configuration-load wait.
- R11: Pin activity during the power-on stretch and the configuration-load wait is ignored, as long as the pin is high again before ready rises.
- R12: ready and chipRst are never 1 at the same time.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| porDetect | input | 1 | Power-on detect, high while supply is coming up |
| extRstN | input | 1 | Board reset pin, active low, asynchronous |
| unpowered | input | 1 | High while the chip is in its unpowered state |
| softRstReq | input | 1 | Soft-reset request, sampled each cycle |
| eeLoadDone | input | 1 | Configuration-memory load has finished |
| chipRst | output | 1 | Internal chip reset, active high |
| eeLoadStart | output | 1 | One-cycle start strobe for the configuration load |
| phyPowerDown | output | 1 | One-cycle request placing the PHY in power-down |
| ready | output | 1 | Host-visible ready flag |

## Verification
The assertions assume that porDetect is high at the first clock edge, so every register has a defined value before any property is enabled. They also assume that porDetect, unpowered, softRstReq and eeLoadDone are synchronous to clk, while only extRstN may change at any time. The properties further take for granted that eeLoadDone is raised only after an eeLoadStart strobe. The bench changes every input on the falling edge, starts with porDetect asserted, and raises eeLoadDone only during the load wait that follows the strobe.

// File: rtl/rst_seq_pkg.sv
package rst_seq_pkg;

  typedef enum logic [2:0] {
    ST_POWERON  = 3'd0,
    ST_CFGLOAD  = 3'd1,
    ST_RUN      = 3'd2,
    ST_PINHOLD  = 3'd3,
    ST_SOFTHOLD = 3'd4
  } seqState_e;

  // control to datapath
  typedef struct packed {
    logic clrTimer;
    logic runTimer;
    logic selSoft;
  } seqStrobe_t;

  // datapath to control
  typedef struct packed {
    logic pinAsserted;
    logic pinHigh;
    logic timerDone;
  } seqStatus_t;

  function automatic int unsigned cyclesFor(input int unsigned clkKhz,
                                            input int unsigned durUs);
    return (clkKhz * durUs) / 1000;
  endfunction

endpackage

// File: rtl/rst_seq_dpath.sv
module rst_seq_dpath
  import rst_seq_pkg::*;
#(
  parameter int unsigned POR_CYCLES     = 550000,
  parameter int unsigned SOFT_CYCLES    = 16,
  parameter int unsigned PIN_MIN_CYCLES = 64,
  parameter int unsigned SYNC_STAGES    = 2
) (
  input  logic       clk,
  input  logic       holdAll,
  input  logic       extRstN,
  input  seqStrobe_t strobe,
  output seqStatus_t status
);

  localparam int unsigned TimerMax = (POR_CYCLES > SOFT_CYCLES) ? POR_CYCLES : SOFT_CYCLES;
  localparam int unsigned TimerW   = $clog2(TimerMax + 1);
  localparam int unsigned FiltW    = $clog2(PIN_MIN_CYCLES + 1);
  localparam logic [TimerW-1:0] PorLast  = TimerW'(POR_CYCLES - 1);
  localparam logic [TimerW-1:0] SoftLast = TimerW'(SOFT_CYCLES - 1);
  localparam logic [FiltW-1:0]  FiltFull = FiltW'(PIN_MIN_CYCLES);

  // pin synchronizer, resets to the inactive (high) level
  logic [SYNC_STAGES-1:0] syncQ;
  logic pinSynced;

  generate
    if (SYNC_STAGES == 1) begin : g_sync1
      always_ff @(posedge clk) begin
        if (holdAll) syncQ <= '1;
        else         syncQ <= extRstN;
      end
    end else begin : g_syncN
      always_ff @(posedge clk) begin
        if (holdAll) syncQ <= '1;
        else         syncQ <= {syncQ[SYNC_STAGES-2:0], extRstN};
      end
    end
  endgenerate

  assign pinSynced = syncQ[SYNC_STAGES-1];

  // low-time filter: counts consecutive low samples, saturating
  logic [FiltW-1:0] lowCnt;

  always_ff @(posedge clk) begin
    if (holdAll || pinSynced) lowCnt <= '0;
    else if (lowCnt != FiltFull) lowCnt <= lowCnt + 1'b1;
  end

  // shared stretch timer for power-on and soft reset
  logic [TimerW-1:0] timerCnt;
  logic [TimerW-1:0] timerLast;

  always_ff @(posedge clk) begin
    if (holdAll || strobe.clrTimer) timerCnt <= '0;
    else if (strobe.runTimer)       timerCnt <= timerCnt + 1'b1;
  end

  always_comb begin
    timerLast          = strobe.selSoft ? SoftLast : PorLast;
    status.timerDone   = strobe.runTimer && (timerCnt == timerLast);
    status.pinAsserted = (lowCnt == FiltFull);
    status.pinHigh     = pinSynced;
  end

endmodule

// File: rtl/rst_seq_ctrl.sv
module rst_seq_ctrl
  import rst_seq_pkg::*;
(
  input  logic       clk,
  input  logic       holdAll,
  input  logic       softRstReq,
  input  logic       eeLoadDone,
  input  seqStatus_t status,
  output seqStrobe_t strobe,
  output logic       chipRst,
  output logic       eeLoadStart,
  output logic       phyPowerDown,
  output logic       ready
);

  seqState_e state, nextState;
  logic porRelease, pinRelease;

  always_comb begin
    nextState = state;
    unique case (state)
      ST_POWERON:  if (status.timerDone) nextState = ST_CFGLOAD;
      ST_CFGLOAD:  if (eeLoadDone)       nextState = ST_RUN;
      ST_RUN: begin
        if (status.pinAsserted) nextState = ST_PINHOLD;
        else if (softRstReq)    nextState = ST_SOFTHOLD;
      end
      ST_PINHOLD:  if (status.pinHigh)   nextState = ST_RUN;
      ST_SOFTHOLD: begin
        if (status.pinAsserted)    nextState = ST_PINHOLD;
        else if (status.timerDone) nextState = ST_RUN;
      end
      default:                           nextState = ST_POWERON;
    endcase
  end

  always_ff @(posedge clk) begin
    if (holdAll) state <= ST_POWERON;
    else         state <= nextState;
  end

  assign porRelease = (state == ST_POWERON) && (nextState == ST_CFGLOAD);
  assign pinRelease = (state == ST_PINHOLD) && (nextState == ST_RUN);

  always_ff @(posedge clk) begin
    if (holdAll) begin
      eeLoadStart  <= 1'b0;
      phyPowerDown <= 1'b0;
    end else begin
      eeLoadStart  <= porRelease;
      phyPowerDown <= porRelease || pinRelease;
    end
  end

  always_comb begin
    strobe.runTimer = ((state == ST_POWERON) && !holdAll) || (state == ST_SOFTHOLD);
    strobe.clrTimer = holdAll || !strobe.runTimer;
    strobe.selSoft  = (state == ST_SOFTHOLD);
    chipRst = (state == ST_POWERON) || (state == ST_PINHOLD) || (state == ST_SOFTHOLD);
    ready   = (state == ST_RUN);
  end

endmodule

// File: rtl/chip_reset_seq.sv
module chip_reset_seq
  import rst_seq_pkg::*;
#(
  parameter int unsigned CLK_KHZ        = 25000,
  parameter int unsigned POR_STRETCH_US = 22000,
  parameter int unsigned PIN_MIN_CYCLES = 64,
  parameter int unsigned SOFT_CYCLES    = 16,
  parameter int unsigned SYNC_STAGES    = 2
) (
  input  logic clk,
  input  logic porDetect,
  input  logic extRstN,
  input  logic unpowered,
  input  logic softRstReq,
  input  logic eeLoadDone,
  output logic chipRst,
  output logic eeLoadStart,
  output logic phyPowerDown,
  output logic ready
);

  localparam int unsigned PorCycles = cyclesFor(CLK_KHZ, POR_STRETCH_US);

  logic       holdAll;
  seqStrobe_t strobe;
  seqStatus_t status;

  assign holdAll = porDetect | unpowered;

  rst_seq_dpath #(
    .POR_CYCLES     (PorCycles),
    .SOFT_CYCLES    (SOFT_CYCLES),
    .PIN_MIN_CYCLES (PIN_MIN_CYCLES),
    .SYNC_STAGES    (SYNC_STAGES)
  ) i_dpath (
    .clk     (clk),
    .holdAll (holdAll),
    .extRstN (extRstN),
    .strobe  (strobe),
    .status  (status)
  );

  rst_seq_ctrl i_ctrl (
    .clk          (clk),
    .holdAll      (holdAll),
    .softRstReq   (softRstReq),
    .eeLoadDone   (eeLoadDone),
    .status       (status),
    .strobe       (strobe),
    .chipRst      (chipRst),
    .eeLoadStart  (eeLoadStart),
    .phyPowerDown (phyPowerDown),
    .ready        (ready)
  );

endmodule

// File: rtl/chip_reset_seq_chk.sv
module chip_reset_seq_chk (
  input logic clk,
  input logic porDetect,
  input logic extRstN,
  input logic unpowered,
  input logic softRstReq,
  input logic eeLoadDone,
  input logic chipRst,
  input logic eeLoadStart,
  input logic phyPowerDown,
  input logic ready
);

  logic holdAll;
  assign holdAll = porDetect | unpowered;

  assert_hold_forces_reset_R1: assert property (@(posedge clk)
    holdAll |=> (chipRst && !ready && !eeLoadStart && !phyPowerDown));

  assert_load_pulse_single_R3: assert property (@(posedge clk) disable iff (holdAll)
    eeLoadStart |=> !eeLoadStart);

  assert_load_with_powerdown_R3: assert property (@(posedge clk) disable iff (holdAll)
    eeLoadStart |-> (phyPowerDown && !chipRst && !ready));

  assert_ready_after_release_R4: assert property (@(posedge clk) disable iff (holdAll)
    $rose(ready) |-> ($past(chipRst) || $past(eeLoadDone)));

  assert_powerdown_single_R7: assert property (@(posedge clk) disable iff (holdAll)
    phyPowerDown |=> !phyPowerDown);

  assert_soft_no_load_R9: assert property (@(posedge clk) disable iff (holdAll)
    (ready && softRstReq) |=> (chipRst && !eeLoadStart && !phyPowerDown));

  assert_ready_excl_reset_R12: assert property (@(posedge clk) disable iff (holdAll)
    !(ready && chipRst));

endmodule

bind chip_reset_seq chip_reset_seq_chk i_chk (.*);

// File: tb/test_chip_reset_seq.sv
module test_chip_reset_seq;

  localparam int ClkPeriod  = 10;
  localparam int ClkKhz     = 1000;
  localparam int StretchUs  = 40;
  localparam int PorCycles  = ClkKhz * StretchUs / 1000;
  localparam int PinMin     = 8;
  localparam int SoftCycles = 5;

  logic clk = 1'b0;
  logic porDetect = 1'b1, extRstN = 1'b1, unpowered = 1'b0;
  logic softRstReq = 1'b0, eeLoadDone = 1'b0;
  logic chipRst, eeLoadStart, phyPowerDown, ready;

  int checks = 0;
  int failures = 0;
  int overlap = 0;

  always #(ClkPeriod/2) clk = ~clk;

  chip_reset_seq #(
    .CLK_KHZ(ClkKhz), .POR_STRETCH_US(StretchUs),
    .PIN_MIN_CYCLES(PinMin), .SOFT_CYCLES(SoftCycles), .SYNC_STAGES(2)
  ) i_chip_reset_seq (
    .clk(clk), .porDetect(porDetect), .extRstN(extRstN), .unpowered(unpowered),
    .softRstReq(softRstReq), .eeLoadDone(eeLoadDone), .chipRst(chipRst),
    .eeLoadStart(eeLoadStart), .phyPowerDown(phyPowerDown), .ready(ready)
  );

  always @(negedge clk) if (!porDetect && !unpowered && ready && chipRst) overlap++;

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  // drops both hold inputs and checks the stretch and release strobes
  task automatic powerOn(input string req);
    int cnt = 0;
    porDetect = 1'b0;
    unpowered = 1'b0;
    do begin
      tick(1);
      cnt++;
    end while (chipRst && cnt < 1000);
    chk(req, "stretch length", cnt, PorCycles);
    chk("R3", "eeLoadStart at release", int'(eeLoadStart), 1);
    chk("R3", "phyPowerDown at release", int'(phyPowerDown), 1);
    tick(1);
    chk("R3", "eeLoadStart one cycle", int'(eeLoadStart), 0);
    chk("R3", "phyPowerDown one cycle", int'(phyPowerDown), 0);
  endtask

  task automatic finishLoad();
    eeLoadDone = 1'b1;
    tick(1);
    eeLoadDone = 1'b0;
    chk("R4", "ready after load done", int'(ready), 1);
  endtask

  task automatic testResetState();
    tick(5);
    chk("R1", "chipRst in hold", int'(chipRst), 1);
    chk("R1", "ready in hold", int'(ready), 0);
    chk("R1", "strobes in hold", int'(eeLoadStart || phyPowerDown), 0);
  endtask

  task automatic testPowerOn();
    int bad = 0;
    powerOn("R2");
    for (int i = 0; i < 6; i++) begin
      if (ready || chipRst) bad++;
      tick(1);
    end
    chk("R4", "waiting for load done", bad, 0);
    finishLoad();
  endtask

  task automatic testShortPulse();
    int bad = 0;
    extRstN = 1'b0;
    tick(PinMin - 1);
    extRstN = 1'b1;
    for (int i = 0; i < PinMin + 6; i++) begin
      if (chipRst || !ready) bad++;
      tick(1);
    end
    chk("R6", "short pin pulse ignored", bad, 0);
  endtask

  task automatic testPinReset();
    int bad = 0;
    int cnt = 0;
    extRstN = 1'b0;
    tick(PinMin + 3);
    chk("R5", "chipRst after filtered low", int'(chipRst), 1);
    chk("R5", "ready after filtered low", int'(ready), 0);
    for (int i = 0; i < 10; i++) begin
      if (!chipRst) bad++;
      tick(1);
    end
    chk("R5", "held while pin low", bad, 0);
    extRstN = 1'b1;
    do begin
      tick(1);
      cnt++;
    end while (chipRst && cnt < 100);
    chk("R7", "edges to release", cnt, 3);
    chk("R7", "ready at release", int'(ready), 1);
    chk("R7", "phyPowerDown at release", int'(phyPowerDown), 1);
    chk("R7", "no eeLoadStart", int'(eeLoadStart), 0);
    tick(1);
    chk("R7", "phyPowerDown one cycle", int'(phyPowerDown), 0);
  endtask

  task automatic testSoftReset();
    int hi = 0;
    int saw = 0;
    softRstReq = 1'b1;
    tick(1);
    softRstReq = 1'b0;
    while (chipRst && hi < 100) begin
      hi++;
      if (eeLoadStart || phyPowerDown || ready) saw++;
      tick(1);
    end
    chk("R9", "soft reset length", hi, SoftCycles);
    chk("R9", "no strobes or ready in soft", saw, 0);
    chk("R9", "ready after soft", int'(ready), 1);
  endtask

  task automatic testLoadWaitNoise();
    int bad = 0;
    porDetect = 1'b1;
    tick(3);
    powerOn("R2");
    extRstN = 1'b0;
    tick(2 * PinMin);
    extRstN = 1'b1;
    tick(4);
    chk("R11", "pin ignored in load wait", int'(chipRst || ready), 0);
    softRstReq = 1'b1;
    tick(1);
    softRstReq = 1'b0;
    tick(2);
    chk("R10", "soft ignored in load wait", int'(chipRst || ready), 0);
    finishLoad();
    for (int i = 0; i < SoftCycles + PinMin; i++) begin
      if (chipRst || !ready) bad++;
      tick(1);
    end
    chk("R10", "no late reset after load (R11 too)", bad, 0);
  endtask

  task automatic testUnpowered();
    int bad = 0;
    unpowered = 1'b1;
    tick(1);
    chk("R8", "chipRst when unpowered", int'(chipRst), 1);
    chk("R8", "ready when unpowered", int'(ready), 0);
    extRstN = 1'b0;
    for (int i = 0; i < 3 * PinMin; i++) begin
      if (!chipRst || ready || eeLoadStart || phyPowerDown) bad++;
      tick(1);
    end
    extRstN = 1'b1;
    tick(4);
    chk("R8", "pin ignored when unpowered", bad, 0);
    powerOn("R8");
    finishLoad();
  endtask

  initial begin
    tick(1);
    testResetState();
    testPowerOn();
    testShortPulse();
    testPinReset();
    testSoftReset();
    testLoadWaitNoise();
    testUnpowered();
    testSoftReset();
    chk("R12", "ready with chipRst", overlap, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    failures++;
    $display("FAIL watchdog: actual=expired expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule